// File: doc/BRIEF.md
# Timed-State Waveform Pattern Sequencer

This block turns a stream of 24-bit pattern words from a host processor into the clock and control lines of an image-sensor readout chain. Each word carries two things: the levels to put on the lines, and how long those levels must stay before the next word may take effect. The block registers the pattern onto one of two output ports, loads an 8-bit dwell counter from the word, and holds its write-ready signal low until that counter rolls over. The host therefore never programs a separate timer. It keeps offering words, and the block paces them.

A per-word select input routes the pattern either to the wide port (16 lines) or to the narrow port (12 lines). The port that is not selected keeps its lines. Dwell time is measured in ticks. An internal divider produces one tick every `TICK_DIV` clocks; the default of 5 at a 50 MHz clock gives a 100 ns tick. The divider phase restarts on every accepted word, so each state lasts an exact whole number of ticks. Delays longer than 256 ticks are built by writing the same pattern again.

Top module: `tsw_sequencer`

## Requirements
- R1: A word sits on `wr_word` with the dwell field in bits 23:16 and the line pattern in bits 15:0. When it is accepted with `wr_port_b` = 0, `out_a` takes bits 15:0.
- R2: When a word is accepted with `wr_port_b` = 1, `out_b` takes bits 11:0 of the word. Bits 15:12 are dropped.
- R3: The port not chosen by the accepted word keeps its previous value.
- R4: A word is accepted on a rising clock edge where `wr_valid` and `wr_ready` are both high. The new pattern is visible on the outputs directly after that edge.
- R5: A dwell field value D holds the state for 256 − D ticks, so 0xFF gives 1 tick and 0x00 gives 256 ticks. A tick is `TICK_DIV` clocks, counted from the accepting edge. With no new word offered, `wr_ready` is low for exactly (256 − D)·`TICK_DIV` − 1 clock cycles after the accepting edge.
- R6: `wr_ready` is high while no dwell is pending. It also rises within the final clock of the last tick, so a word held valid is accepted on the rollover edge and each state lasts exactly (256 − D)·`TICK_DIV` clocks.
- R7: Words offered while `wr_ready` is low are ignored. Both ports hold their values for the whole dwell.
- R8: A synchronous active-high reset drives both ports to zero, drops any pending dwell and leaves `wr_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | A pattern word is offered |
| wr_port_b | input | 1 | 0: word updates port A, 1: word updates port B |
| wr_word | input | 24 | Dwell field (23:16) and line pattern (15:0) |
| wr_ready | output | 1 | Block will take a word on this edge |
| out_a | output | 16 | Wide line port, registered |
| out_b | output | 12 | Narrow line port, registered |

## Verification
The bench goes after the two ends of the dwell range. A design that counts the wrong direction, or stops one step early, gives 255 or 257 ticks for a field of 0x00 and zero or two ticks for 0xFF. Back-to-back words held valid across the rollover catch a ready that comes one clock late, which would stretch every state by a cycle. They also catch a design in which a finishing dwell overrides the freshly loaded one. Junk words offered mid-dwell, and a reset in the middle of a long dwell followed by a one-tick word, expose a design that lets stalled writes through or keeps a stale count or divider phase.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
   localparam int DWELL_W_DEF  = 8;
   localparam int PAT_W_DEF    = 16;
   localparam int NARROW_W_DEF = 12;
   localparam int TICK_DIV_DEF = 5;

   typedef enum logic {
      SEL_WIDE   = 1'b0,
      SEL_NARROW = 1'b1
   } port_sel_e;
endpackage

// File: rtl/tsw_tick_gen.sv
module tsw_tick_gen #(
   parameter int TICK_DIV = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic tick
);
   generate
      if (TICK_DIV == 1) begin : g_every_clock
         logic unused_inputs;
         assign unused_inputs = restart ^ rst ^ clk;
         assign tick = 1'b1;
      end else begin : g_divider
         localparam int DIV_W = $clog2(TICK_DIV);
         localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);
         logic [DIV_W-1:0] phase;

         always_ff @(posedge clk) begin
            if (rst || restart)
               phase <= '0;
            else if (phase == LAST)
               phase <= '0;
            else
               phase <= phase + 1'b1;
         end

         assign tick = (phase == LAST);
      end
   endgenerate
endmodule

// File: rtl/tsw_dwell_ctr.sv
module tsw_dwell_ctr #(
   parameter int DWELL_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load,
   input  logic [DWELL_W-1:0] load_val,
   input  logic               tick,
   output logic               busy,
   output logic               last
);
   localparam logic [DWELL_W-1:0] TOP = '1;
   logic [DWELL_W-1:0] count;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy  <= 1'b0;
         count <= '0;
      end else if (load) begin
         busy  <= 1'b1;
         count <= load_val;
      end else if (busy && tick) begin
         if (count == TOP)
            busy <= 1'b0;
         count <= count + 1'b1;
      end
   end

   assign last = busy && tick && (count == TOP);
endmodule

// File: rtl/tsw_line_bank.sv
module tsw_line_bank
   import tsw_pkg::*;
#(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  port_sel_e         sel,
   input  logic [WIDE_W-1:0] pattern,
   output logic [WIDE_W-1:0]   lines_wide,
   output logic [NARROW_W-1:0] lines_narrow
);
   always_ff @(posedge clk) begin
      if (rst)
         lines_wide <= '0;
      else if (wr_en && sel == SEL_WIDE)
         lines_wide <= pattern;
   end

   generate
      if (NARROW_W == WIDE_W) begin : g_full_narrow
         always_ff @(posedge clk) begin
            if (rst)
               lines_narrow <= '0;
            else if (wr_en && sel == SEL_NARROW)
               lines_narrow <= pattern;
         end
      end else begin : g_sliced_narrow
         always_ff @(posedge clk) begin
            if (rst)
               lines_narrow <= '0;
            else if (wr_en && sel == SEL_NARROW)
               lines_narrow <= pattern[NARROW_W-1:0];
         end
      end
   endgenerate
endmodule

// File: rtl/tsw_sequencer.sv
module tsw_sequencer
   import tsw_pkg::*;
#(
   parameter int DWELL_W  = DWELL_W_DEF,
   parameter int WIDE_W   = PAT_W_DEF,
   parameter int NARROW_W = NARROW_W_DEF,
   parameter int TICK_DIV = TICK_DIV_DEF,
   localparam int WORD_W  = DWELL_W + WIDE_W
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_valid,
   input  logic                wr_port_b,
   input  logic [WORD_W-1:0]   wr_word,
   output logic                wr_ready,
   output logic [WIDE_W-1:0]   out_a,
   output logic [NARROW_W-1:0] out_b
);
   generate
      if (NARROW_W > WIDE_W || NARROW_W < 1) begin : g_bad_narrow
         $error("narrow port must be 1..WIDE_W lines");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (DWELL_W < 1) begin : g_bad_dwell
         $error("DWELL_W must be at least 1");
      end
   endgenerate

   logic      accept;
   logic      tick;
   logic      busy;
   logic      last;
   port_sel_e sel;

   assign wr_ready = !busy || last;
   assign accept   = wr_valid && wr_ready;
   assign sel      = wr_port_b ? SEL_NARROW : SEL_WIDE;

   tsw_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk     (clk),
      .rst     (rst),
      .restart (accept),
      .tick    (tick)
   );

   tsw_dwell_ctr #(.DWELL_W(DWELL_W)) u_dwell (
      .clk      (clk),
      .rst      (rst),
      .load     (accept),
      .load_val (wr_word[WORD_W-1 -: DWELL_W]),
      .tick     (tick),
      .busy     (busy),
      .last     (last)
   );

   tsw_line_bank #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_lines (
      .clk          (clk),
      .rst          (rst),
      .wr_en        (accept),
      .sel          (sel),
      .pattern      (wr_word[WIDE_W-1:0]),
      .lines_wide   (out_a),
      .lines_narrow (out_b)
   );
endmodule

// File: rtl/tsw_sequencer_chk.sv
module tsw_sequencer_chk #(
   parameter int DWELL_W  = 8,
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 12,
   parameter int TICK_DIV = 5,
   localparam int WORD_W  = DWELL_W + WIDE_W
) (
   input logic                clk,
   input logic                rst,
   input logic                wr_valid,
   input logic                wr_port_b,
   input logic [WORD_W-1:0]   wr_word,
   input logic                wr_ready,
   input logic [WIDE_W-1:0]   out_a,
   input logic [NARROW_W-1:0] out_b
);
   logic take;
   assign take = wr_valid && wr_ready;

   assert_wide_load_R1: assert property (@(posedge clk) disable iff (rst)
      (take && !wr_port_b) |=> (out_a == $past(wr_word[WIDE_W-1:0])) && $stable(out_b));

   assert_narrow_load_R2: assert property (@(posedge clk) disable iff (rst)
      (take && wr_port_b) |=> (out_b == $past(wr_word[NARROW_W-1:0])) && $stable(out_a));

   assert_stall_after_take_R5: assert property (@(posedge clk) disable iff (rst)
      (take && (TICK_DIV > 1 || wr_word[WORD_W-1 -: DWELL_W] != '1)) |=> !wr_ready);

   assert_hold_without_take_R7: assert property (@(posedge clk) disable iff (rst)
      !take |=> $stable(out_a) && $stable(out_b));

   assert_reset_clears_R8: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (out_a == '0) && (out_b == '0) && wr_ready);
endmodule

bind tsw_sequencer tsw_sequencer_chk #(
   .DWELL_W  (DWELL_W),
   .WIDE_W   (WIDE_W),
   .NARROW_W (NARROW_W),
   .TICK_DIV (TICK_DIV)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .wr_valid  (wr_valid),
   .wr_port_b (wr_port_b),
   .wr_word   (wr_word),
   .wr_ready  (wr_ready),
   .out_a     (out_a),
   .out_b     (out_b)
);

// File: tb/tb_tsw_sequencer.sv
module tb_tsw_sequencer;
   localparam int TD = 5;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_valid = 1'b0;
   logic        wr_port_b = 1'b0;
   logic [23:0] wr_word = '0;
   logic        wr_ready;
   logic [15:0] out_a;
   logic [11:0] out_b;

   int checks = 0;
   int fails  = 0;
   logic [15:0] exp_a = '0;
   logic [11:0] exp_b = '0;

   always #10 clk = ~clk;

   tsw_sequencer #(.TICK_DIV(TD)) dut (
      .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_port_b(wr_port_b),
      .wr_word(wr_word), .wr_ready(wr_ready), .out_a(out_a), .out_b(out_b)
   );

   function automatic int exp_low(input logic [7:0] d);
      return (256 - int'(d)) * TD - 1;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Called just after a falling edge; returns on the falling edge where ready is high.
   task automatic send(input logic [7:0] d, input logic [15:0] pat,
                       input bit to_b, input bit inject);
      int low = 0;
      bit steady = 1'b1;
      chk(wr_ready === 1'b1, "R6", "ready when word offered", int'(wr_ready), 1);
      wr_valid = 1'b1; wr_word = {d, pat}; wr_port_b = to_b;
      @(posedge clk); @(negedge clk);
      wr_valid = 1'b0;
      if (to_b) exp_b = pat[11:0]; else exp_a = pat;
      chk(out_a === exp_a, to_b ? "R3" : "R1,R4", "out_a after accept", int'(out_a), int'(exp_a));
      chk(out_b === exp_b, to_b ? "R2,R4" : "R3", "out_b after accept", int'(out_b), int'(exp_b));
      while (wr_ready !== 1'b1 && low < 4000) begin
         low++;
         if (out_a !== exp_a || out_b !== exp_b) steady = 1'b0;
         if (inject && low == 2) begin
            wr_valid = 1'b1; wr_word = ~{d, pat}; wr_port_b = ~to_b;
         end
         @(negedge clk);
      end
      wr_valid = 1'b0;
      if (out_a !== exp_a || out_b !== exp_b) steady = 1'b0;
      chk(low == exp_low(d), "R5", "ready-low cycles", low, exp_low(d));
      chk(steady, "R7", "ports steady during dwell", int'(steady), 1);
   endtask

   initial begin
      #4_000_000;
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'h5EC0_0D1E);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R8 reset state
      chk(out_a === 16'h0 && out_b === 12'h0, "R8", "ports at reset", int'({out_a, out_b}), 0);
      chk(wr_ready === 1'b1, "R8", "ready at reset", int'(wr_ready), 1);

      // Directed corners: shortest, longest, narrow port with high bits set
      send(8'hFF, 16'hA5C3, 1'b0, 1'b0);
      send(8'h00, 16'hFFFF, 1'b1, 1'b1);
      send(8'hFE, 16'h1234, 1'b1, 1'b0);
      repeat (7) @(negedge clk);
      send(8'hF0, 16'h0F0F, 1'b0, 1'b1);

      // Reset in the middle of a long dwell (R8)
      wr_valid = 1'b1; wr_word = {8'h00, 16'hBEEF}; wr_port_b = 1'b0;
      @(posedge clk); @(negedge clk);
      wr_valid = 1'b0;
      repeat (23) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      exp_a = '0; exp_b = '0;
      chk(out_a === 16'h0 && out_b === 12'h0, "R8", "ports after mid-dwell reset", int'({out_a, out_b}), 0);
      chk(wr_ready === 1'b1, "R8", "ready after mid-dwell reset", int'(wr_ready), 1);
      send(8'hFF, 16'h00C3, 1'b1, 1'b0);

      // Constrained random, mostly back-to-back
      for (int i = 0; i < 40; i++) begin
         logic [7:0] d;
         d = 8'(224 + $urandom_range(31));
         send(d, 16'($urandom), 1'($urandom_range(1)), 1'($urandom_range(1)));
         if ($urandom_range(3) == 0) repeat ($urandom_range(6)) @(negedge clk);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule